// File: doc/BRIEF.md
# CAN Controller Status Register

This block keeps the status word of a CAN controller: a three-bit last-error code and two sticky flags that report a good transmission and a good reception. A protocol engine drives it with one-cycle event pulses. These pulses cover the six error kinds, an error-free transfer, a transmission that was acknowledged, and a finished reception. A CPU reads and writes the same word through a plain register port. Fixed priority rules settle cycles in which the CPU and the hardware touch the same field, so that no hardware event is lost.

The error code resets itself to zero after every clean transfer. Software can load the code value that hardware never produces, so that it can see when hardware next writes the field. The two flags are set only by hardware and cleared only by software. While the node recovers from bus-off, the block counts recessive bits on the bus. It loads the bit0 error code each time it has seen a full run of them, which lets software follow the recovery.

Top module: `can_stat_reg`

## Requirements
- R1: After reset the word read on `cpu_rdata_o` is 0: code field 0, both flags 0.
- R2: Bits 2:0 hold the last error code: 0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC, 7 unused. A pulse on `err_pulse_i[k]` records code k+1 at the next clock edge.
- R3: When several bits of `err_pulse_i` are high in one cycle, the code recorded is the highest of their codes.
- R4: A pulse on `xfer_ok_i` forces the code field to 0 if no error pulse arrives in the same cycle. If an error pulse does arrive in that cycle, the error code is recorded.
- R5: A CPU write (`cpu_wr_i`) stores `cpu_wdata_i[2:0]` in the code field, including 7. Hardware never produces 7. A hardware error or clean-transfer event in the same cycle overrides the CPU value.
- R6: Bit 3 (transmit OK) is set by `tx_acked_i` and holds until a CPU write with `cpu_wdata_i[3]`=0. A CPU write of 1 to that bit leaves it unchanged.
- R7: Bit 4 (receive OK) is set by `rx_done_i` and holds until a CPU write with `cpu_wdata_i[4]`=0. A CPU write of 1 to that bit leaves it unchanged.
- R8: A hardware set of either flag in the same cycle as a CPU clear of that flag leaves the flag set.
- R9: While `recov_i` is high, every run of RUN_LEN (default 11) consecutive strobed recessive bits (`bit_strobe_i`=1, `bus_bit_i`=1) loads code 5. A strobed dominant bit restarts the run. Cycles without a strobe do not count. Dropping `recov_i` restarts the run.
- R10: Clearing one flag by CPU write leaves the other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_pulse_i | input | 6 | Error event pulses, bit k = code k+1 |
| xfer_ok_i | input | 1 | Transfer finished without error |
| tx_acked_i | input | 1 | Transmission finished and acknowledged |
| rx_done_i | input | 1 | Error-free reception finished |
| recov_i | input | 1 | Bus-off recovery in progress |
| bit_strobe_i | input | 1 | Sampled bus bit valid this cycle |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 5 | CPU write data |
| cpu_rdata_o | output | 5 | Status word {rxok, txok, code} |

## Verification
The bench sweeps all 63 non-empty error pulse patterns and compares the recorded code with the highest set index plus one. A design with a wrong priority encoder would record a lower code or a code of 7. After each pattern it issues a clean transfer, which catches a code that fails to clear. It also drives every same-cycle collision between the CPU and hardware: a write against an error, a clear against a flag set, and a write of 1 to a flag. A wrong priority order would lose a hardware event or let software set a flag. For the recovery run the bench checks the code just before and at the eleventh recessive bit. It also checks that a dominant bit, an unstrobed cycle or a drop of recovery restarts the count. A design that counts off by one, or counts unstrobed cycles, reports recovery too early or too late.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int CODE_W  = 3;
  localparam int NUM_ERR = 6;
  localparam int WORD_W  = CODE_W + 2;
  localparam int TXOK_POS = CODE_W;
  localparam int RXOK_POS = CODE_W + 1;

  typedef enum logic [CODE_W-1:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_SENT  = 3'd7
  } lec_e;

  // index in the error pulse vector that maps to the recovery code
  localparam int RECOV_IDX = int'(LEC_BIT0) - 1;
endpackage

// File: rtl/lec_unit.sv
module lec_unit
  import can_stat_pkg::*;
#(
  parameter int N_ERR = NUM_ERR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_ERR-1:0]  err_i,
  input  logic              clean_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wcode_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] hi_code;
  logic              any_err;
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    hi_code = '0;
    for (int i = 0; i < N_ERR; i++)
      if (err_i[i]) hi_code = CODE_W'(i + 1);
  end

  assign any_err = |err_i;

  always_comb begin
    code_d = code_q;
    if (any_err)      code_d = hi_code;
    else if (clean_i) code_d = LEC_NONE;
    else if (wr_i)    code_d = wcode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) code_q <= LEC_NONE;
    else         code_q <= code_d;

  assign code_o = code_q;

  a_r3_top_error_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i[N_ERR-1] |=> code_o == CODE_W'(N_ERR));
  a_r4_clean_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clean_i && !any_err) |=> code_o == LEC_NONE);
  a_r5_no_hw_sentinel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != LEC_SENT && !(wr_i && wcode_i == LEC_SENT)) |=> code_o != LEC_SENT);
  a_r2_error_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_err |=> code_o != LEC_NONE);
endmodule

// File: rtl/ok_flag.sv
module ok_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // hardware set outranks software clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;

  assign flag_o = flag_q;

  a_r8_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r7_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/busoff_mon.sv
module busoff_mon #(
  parameter int RUN_LEN = 11,
  localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recov_i,
  input  logic strobe_i,
  input  logic bit_i,
  output logic hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last  = (cnt_q == CNT_W'(RUN_LEN - 1));
  assign hit_o = recov_i && strobe_i && bit_i && last;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cnt_q <= '0;
    else if (!recov_i)          cnt_q <= '0;
    else if (strobe_i) begin
      if (!bit_i || last)       cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(RUN_LEN));
  a_r9_idle_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !recov_i |=> cnt_q == '0);
  a_r9_dominant_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !bit_i) |=> cnt_q == '0);
endmodule

// File: rtl/can_stat_reg.sv
module can_stat_reg
  import can_stat_pkg::*;
#(
  parameter int RUN_LEN = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_ERR-1:0] err_pulse_i,
  input  logic              xfer_ok_i,
  input  logic              tx_acked_i,
  input  logic              rx_done_i,
  input  logic              recov_i,
  input  logic              bit_strobe_i,
  input  logic              bus_bit_i,
  input  logic              cpu_wr_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic [WORD_W-1:0] cpu_rdata_o
);
  logic               recov_hit;
  logic [NUM_ERR-1:0] err_all;
  logic [CODE_W-1:0]  code;
  logic [1:0]         flag_set, flag_clr, flag_q;

  busoff_mon #(.RUN_LEN(RUN_LEN)) u_mon (
    .clk_i, .rst_ni,
    .recov_i, .strobe_i(bit_strobe_i), .bit_i(bus_bit_i),
    .hit_o(recov_hit)
  );

  assign err_all = err_pulse_i | (NUM_ERR'(recov_hit) << RECOV_IDX);

  lec_unit #(.N_ERR(NUM_ERR)) u_lec (
    .clk_i, .rst_ni,
    .err_i(err_all), .clean_i(xfer_ok_i),
    .wr_i(cpu_wr_i), .wcode_i(cpu_wdata_i[CODE_W-1:0]),
    .code_o(code)
  );

  assign flag_set = {rx_done_i, tx_acked_i};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    assign flag_clr[g] = cpu_wr_i && !cpu_wdata_i[TXOK_POS + g];
    ok_flag u_flag (
      .clk_i, .rst_ni,
      .set_i(flag_set[g]), .clr_i(flag_clr[g]),
      .flag_o(flag_q[g])
    );
  end

  assign cpu_rdata_o = {flag_q, code};

  a_r9_recov_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recov_hit && !(|err_pulse_i[NUM_ERR-1:RECOV_IDX+1]))
      |=> cpu_rdata_o[CODE_W-1:0] == LEC_BIT0);
  a_r10_flags_indep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_wdata_i[TXOK_POS] && !tx_acked_i)
      |=> cpu_rdata_o[TXOK_POS] == $past(cpu_rdata_o[TXOK_POS]));
endmodule

// File: tb/sim_can_stat_reg.sv
module sim_can_stat_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] err = '0;
  logic       xok = 0, txa = 0, rxd = 0, rec = 0, stb = 0, bb = 0, wr = 0;
  logic [4:0] wd = '0;
  logic [4:0] rd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  can_stat_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .err_pulse_i(err), .xfer_ok_i(xok),
    .tx_acked_i(txa), .rx_done_i(rxd), .recov_i(rec), .bit_strobe_i(stb),
    .bus_bit_i(bb), .cpu_wr_i(wr), .cpu_wdata_i(wd), .cpu_rdata_o(rd)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample after the rising edge
  task automatic cyc(input logic [5:0] e, input logic x, input logic t, input logic r,
                     input logic w, input logic [4:0] d);
    @(negedge clk);
    err = e; xok = x; txa = t; rxd = r; wr = w; wd = d;
    @(posedge clk); #1;
    @(negedge clk);
    err = '0; xok = 0; txa = 0; rxd = 0; wr = 0; wd = '0;
  endtask

  task automatic bit_in(input logic s, input logic b);
    @(negedge clk);
    stb = s; bb = b;
    @(posedge clk); #1;
    @(negedge clk);
    stb = 0; bb = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #23 rst_n = 1'b1;
    #2 chk("R1 reset word", rd, 5'b0);

    // R2 R3: every non-empty pulse pattern, code = highest index + 1
    for (int v = 1; v < 64; v++) begin
      int hi = 0;
      for (int k = 0; k < 6; k++) if (v[k]) hi = k + 1;
      cyc(6'(v), 0, 0, 0, 0, '0);
      chk(v == (1 << (hi - 1)) ? "R2 single pulse" : "R3 highest wins", rd, 5'(hi));
      cyc('0, 1, 0, 0, 0, '0);
      chk("R4 clean clears", rd, 5'b0);
    end

    // R4: error with clean in the same cycle
    cyc(6'b000100, 1, 0, 0, 0, '0);
    chk("R4 error beats clean", rd, 5'd3);

    // R5: CPU writes, sentinel, overrides
    cyc('0, 0, 0, 0, 1, 5'd7);
    chk("R5 sentinel write", rd, 5'd7);
    cyc('0, 0, 0, 0, 1, 5'd2);
    chk("R5 cpu write", rd, 5'd2);
    cyc(6'b100000, 0, 0, 0, 1, 5'd3);
    chk("R5 error beats write", rd, 5'd6);
    cyc('0, 1, 0, 0, 1, 5'd7);
    chk("R5 clean beats write", rd, 5'd0);

    // R6: transmit OK
    cyc('0, 0, 1, 0, 0, '0);
    chk("R6 tx set", rd, 5'b01000);
    cyc('0, 0, 0, 0, 1, 5'b01000);
    chk("R6 write one keeps", rd, 5'b01000);
    cyc('0, 0, 0, 0, 0, '0);
    chk("R6 holds", rd, 5'b01000);
    cyc('0, 0, 0, 0, 1, 5'b00000);
    chk("R6 cpu clear", rd, 5'b0);
    cyc('0, 0, 0, 0, 1, 5'b01000);
    chk("R6 write one no set", rd, 5'b0);

    // R7: receive OK
    cyc('0, 0, 0, 1, 0, '0);
    chk("R7 rx set", rd, 5'b10000);
    cyc('0, 0, 0, 0, 1, 5'b10000);
    chk("R7 write one keeps", rd, 5'b10000);
    cyc('0, 0, 0, 0, 1, 5'b00000);
    chk("R7 cpu clear", rd, 5'b0);

    // R8: set beats same-cycle clear
    cyc('0, 0, 1, 1, 1, 5'b00000);
    chk("R8 set beats clear", rd, 5'b11000);

    // R10: clear rx only
    cyc('0, 0, 0, 0, 1, 5'b01000);
    chk("R10 other flag kept", rd, 5'b01000);
    cyc('0, 0, 0, 0, 1, 5'b00000);
    chk("R10 clear tx", rd, 5'b0);

    // R9: bus-off recovery runs
    @(negedge clk) rec = 1;
    for (int i = 0; i < 10; i++) bit_in(1, 1);
    chk("R9 ten bits no code", rd, 5'd0);
    bit_in(0, 1);
    chk("R9 unstrobed no count", rd, 5'd0);
    bit_in(1, 1);
    chk("R9 eleventh bit", rd, 5'd5);
    cyc('0, 0, 0, 0, 1, 5'd0);
    for (int i = 0; i < 11; i++) bit_in(1, 1);
    chk("R9 second run", rd, 5'd5);
    cyc('0, 0, 0, 0, 1, 5'd0);
    for (int i = 0; i < 9; i++) bit_in(1, 1);
    bit_in(1, 0);
    for (int i = 0; i < 10; i++) bit_in(1, 1);
    chk("R9 dominant restarts", rd, 5'd0);
    bit_in(1, 1);
    chk("R9 run after dominant", rd, 5'd5);
    cyc('0, 0, 0, 0, 1, 5'd0);
    for (int i = 0; i < 6; i++) bit_in(1, 1);
    @(negedge clk) rec = 0;
    bit_in(1, 1);
    @(negedge clk) rec = 1;
    for (int i = 0; i < 10; i++) bit_in(1, 1);
    chk("R9 drop restarts", rd, 5'd0);
    bit_in(1, 1);
    chk("R9 run after drop", rd, 5'd5);
    @(negedge clk) rec = 0;
    for (int i = 0; i < 12; i++) bit_in(1, 1);
    chk("R9 idle no code", rd, 5'd5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule